// File: doc/BRIEF.md
# Direction-Switchable Byte FIFO with Burst Threshold

This block is a 64-byte data buffer between a 32-bit host or DMA port and a byte-wide card data path. At runtime software picks which way the data flows. In transmit mode the host loads bytes and the card side drains them. In receive mode the card side fills the buffer and the host unloads it. One storage array serves both directions. A clear input empties the buffer and holds it empty for as long as it stays high.

Each host access moves 1, 2 or 4 bytes. The access width input sets the count, and the bytes are packed little-endian in the 32-bit word. A single select bit sets the burst threshold to 16 or 32 bytes. The threshold drives a transmit-ready flag, a receive-ready flag and a DMA request. In transmit mode the DMA request stays off until a kick pulse arms it. If the host writes with too little free space, or reads with too few stored bytes, the access is dropped and a sticky error flag is set.

Top module: `dir_data_fifo`

## Requirements
- R1: While `fifo_clr_i` is high, the FIFO reads as empty (`level_o` = 0). All ready, request and error flags are low, and host or card accesses have no effect. After release the FIFO stays empty until the next push.
- R2: With `dir_tx_i`=1, host writes push bytes and the card output presents them in order. With `dir_tx_i`=0, card input bytes are pushed and host reads return them in order. In transmit mode the card input is refused (`card_in_ready_o`=0). In receive mode host writes change nothing and `card_out_valid_o` stays 0.
- R3: The threshold is 16 bytes when `thresh_sel_i`=0 and 32 bytes when `thresh_sel_i`=1.
- R4: `tx_ready_o` is high exactly when the FIFO is in transmit mode, not held in clear, and free space is at least the threshold.
- R5: `rx_ready_o` is high exactly when the FIFO is in receive mode, not held in clear, and the fill level is at least the threshold.
- R6: `acc_width_i` codes 0, 1 and 2 move 1, 2 and 4 bytes per access, and code 3 also moves 4 bytes. Byte n of an access sits in bits 8n+7:8n. On reads, lanes above the access width return zero.
- R7: A transmit-mode host write that needs more bytes than are free is dropped whole, and it sets `ovf_err_o`. The flag stays set until a clear.
- R8: A receive-mode host read that needs more bytes than are stored is dropped whole, and it sets `unf_err_o`. The flag stays set until a clear.
- R9: In transmit mode `dma_req_o` is high only after a `dma_kick_i` pulse since the last clear, and only while free space is at least the threshold. In receive mode it is high while the fill level is at least the threshold.
- R10: `level_o` reports 0 to 64 stored bytes. At 64 bytes in receive mode, card input is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_clr_i | input | 1 | Hold FIFO empty and clear flags while high |
| dir_tx_i | input | 1 | 1 = transmit (host to card), 0 = receive |
| thresh_sel_i | input | 1 | Threshold select: 0 = 16 bytes, 1 = 32 bytes |
| acc_width_i | input | 2 | Host access width code |
| dma_kick_i | input | 1 | Arms the transmit DMA request |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 32 | Host write data |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 32 | Bytes at the head of the FIFO, width-masked |
| card_out_valid_o | output | 1 | Transmit byte available |
| card_out_byte_o | output | 8 | Transmit byte |
| card_out_ready_i | input | 1 | Card side takes the transmit byte |
| card_in_valid_i | input | 1 | Receive byte offered |
| card_in_byte_i | input | 8 | Receive byte |
| card_in_ready_o | output | 1 | FIFO accepts the receive byte |
| level_o | output | 7 | Stored byte count |
| tx_ready_o | output | 1 | Room for a transmit burst |
| rx_ready_o | output | 1 | Receive burst available |
| dma_req_o | output | 1 | DMA burst request |
| ovf_err_o | output | 1 | Sticky overflow error |
| unf_err_o | output | 1 | Sticky underflow error |

## Verification
A wrong pointer or a wrong lane index shows up as an out-of-order or wrong byte. On the transmit side it appears at `card_out_byte_o` on the first drained byte past the fault. On the receive side it appears at `host_rdata_o` on the next read. A level counter that drifts from the pointers shows up as `level_o` disagreeing with the scoreboard depth. It also moves the ready and request flags across the threshold a burst early or late. In addition, accesses near full or empty are wrongly dropped or accepted, which sets or fails to set the sticky error flags at once. Threshold, width and arming faults are visible on the flags the cycle after the state that feeds them changes.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  typedef enum logic [1:0] {
    ACC_B8   = 2'd0,
    ACC_B16  = 2'd1,
    ACC_B32  = 2'd2,
    ACC_B32X = 2'd3
  } acc_width_e;

  function automatic logic [2:0] acc_bytes(input logic [1:0] code);
    case (acc_width_e'(code))
      ACC_B8:  acc_bytes = 3'd1;
      ACC_B16: acc_bytes = 3'd2;
      default: acc_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dfifo_store.sv
module dfifo_store #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [CW-1:0]      push_n_i,
  input  logic [LANES*8-1:0] push_data_i,
  input  logic [CW-1:0]      pop_n_i,
  output logic [LANES*8-1:0] peek_o,
  output logic [LW-1:0]      level_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(push_n_i)) mem[wr_ptr + AW'(k)] <= push_data_i[k*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_o <= '0;
    end else if (clr_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_o <= '0;
    end else begin
      wr_ptr  <= wr_ptr + AW'(push_n_i);
      rd_ptr  <= rd_ptr + AW'(pop_n_i);
      level_o <= level_o + LW'(push_n_i) - LW'(pop_n_i);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek_o[g*8 +: 8] = mem[rd_ptr + AW'(g)];
  end
endmodule

// File: rtl/dfifo_host_if.sv
module dfifo_host_if
  import dfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic               clr_i,
  input  logic               dir_tx_i,
  input  logic [1:0]         acc_width_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [LW-1:0]      level_i,
  input  logic [LANES*8-1:0] peek_i,
  output logic [CW-1:0]      push_n_o,
  output logic [CW-1:0]      pop_n_o,
  output logic [LANES*8-1:0] rdata_o,
  output logic               ovf_hit_o,
  output logic               unf_hit_o
);
  logic [CW-1:0] nb;
  logic [LW-1:0] free;
  logic          wr_act, rd_act, fits, avail;

  assign nb     = CW'(acc_bytes(acc_width_i));
  assign free   = LW'(DEPTH) - level_i;
  assign fits   = free >= LW'(nb);
  assign avail  = level_i >= LW'(nb);
  assign wr_act = !clr_i && dir_tx_i && wr_i;
  assign rd_act = !clr_i && !dir_tx_i && rd_i;

  assign push_n_o  = (wr_act && fits)  ? nb : '0;
  assign pop_n_o   = (rd_act && avail) ? nb : '0;
  assign ovf_hit_o = wr_act && !fits;
  assign unf_hit_o = rd_act && !avail;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata_o[g*8 +: 8] = (g < int'(nb)) ? peek_i[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/dfifo_flags.sv
module dfifo_flags #(
  parameter int DEPTH  = 64,
  parameter int THR_LO = 16,
  parameter int THR_HI = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          dir_tx_i,
  input  logic          thresh_sel_i,
  input  logic          dma_kick_i,
  input  logic [LW-1:0] level_i,
  input  logic          ovf_hit_i,
  input  logic          unf_hit_i,
  output logic          tx_ready_o,
  output logic          rx_ready_o,
  output logic          dma_req_o,
  output logic          ovf_err_o,
  output logic          unf_err_o
);
  logic [LW-1:0] thr, free;
  logic          armed, room, filled;

  assign thr    = thresh_sel_i ? LW'(THR_HI) : LW'(THR_LO);
  assign free   = LW'(DEPTH) - level_i;
  assign room   = free >= thr;
  assign filled = level_i >= thr;

  assign tx_ready_o = !clr_i && dir_tx_i && room;
  assign rx_ready_o = !clr_i && !dir_tx_i && filled;
  assign dma_req_o  = dir_tx_i ? (tx_ready_o && armed) : rx_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed     <= 1'b0;
      ovf_err_o <= 1'b0;
      unf_err_o <= 1'b0;
    end else if (clr_i) begin
      armed     <= 1'b0;
      ovf_err_o <= 1'b0;
      unf_err_o <= 1'b0;
    end else begin
      if (dma_kick_i && dir_tx_i) armed <= 1'b1;
      if (ovf_hit_i) ovf_err_o <= 1'b1;
      if (unf_hit_i) unf_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dir_data_fifo.sv
module dir_data_fifo #(
  parameter int DEPTH  = 64,
  parameter int HOST_W = 32,
  parameter int THR_LO = 16,
  parameter int THR_HI = 32,
  localparam int LANES = HOST_W / 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_clr_i,
  input  logic              dir_tx_i,
  input  logic              thresh_sel_i,
  input  logic [1:0]        acc_width_i,
  input  logic              dma_kick_i,
  input  logic              host_wr_i,
  input  logic [HOST_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  output logic [HOST_W-1:0] host_rdata_o,
  output logic              card_out_valid_o,
  output logic [7:0]        card_out_byte_o,
  input  logic              card_out_ready_i,
  input  logic              card_in_valid_i,
  input  logic [7:0]        card_in_byte_i,
  output logic              card_in_ready_o,
  output logic [LW-1:0]     level_o,
  output logic              tx_ready_o,
  output logic              rx_ready_o,
  output logic              dma_req_o,
  output logic              ovf_err_o,
  output logic              unf_err_o
);
  logic [CW-1:0]     host_push_n, host_pop_n, push_n, pop_n;
  logic [HOST_W-1:0] peek, push_data;
  logic              ovf_hit, unf_hit, card_pop, card_push;

  assign card_out_valid_o = !fifo_clr_i && dir_tx_i && (level_o != '0);
  assign card_out_byte_o  = peek[7:0];
  assign card_in_ready_o  = !fifo_clr_i && !dir_tx_i && (level_o < LW'(DEPTH));
  assign card_pop         = card_out_valid_o && card_out_ready_i;
  assign card_push        = card_in_valid_i && card_in_ready_o;

  // Direction steers which side feeds and which side drains the shared array
  assign push_n    = dir_tx_i ? host_push_n : CW'(card_push);
  assign pop_n     = dir_tx_i ? CW'(card_pop) : host_pop_n;
  assign push_data = dir_tx_i ? host_wdata_i : HOST_W'(card_in_byte_i);

  dfifo_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (fifo_clr_i),
    .push_n_i    (push_n),
    .push_data_i (push_data),
    .pop_n_i     (pop_n),
    .peek_o      (peek),
    .level_o     (level_o)
  );

  dfifo_host_if #(.DEPTH(DEPTH), .LANES(LANES)) u_host (
    .clr_i       (fifo_clr_i),
    .dir_tx_i    (dir_tx_i),
    .acc_width_i (acc_width_i),
    .wr_i        (host_wr_i),
    .rd_i        (host_rd_i),
    .level_i     (level_o),
    .peek_i      (peek),
    .push_n_o    (host_push_n),
    .pop_n_o     (host_pop_n),
    .rdata_o     (host_rdata_o),
    .ovf_hit_o   (ovf_hit),
    .unf_hit_o   (unf_hit)
  );

  dfifo_flags #(.DEPTH(DEPTH), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (fifo_clr_i),
    .dir_tx_i     (dir_tx_i),
    .thresh_sel_i (thresh_sel_i),
    .dma_kick_i   (dma_kick_i),
    .level_i      (level_o),
    .ovf_hit_i    (ovf_hit),
    .unf_hit_i    (unf_hit),
    .tx_ready_o   (tx_ready_o),
    .rx_ready_o   (rx_ready_o),
    .dma_req_o    (dma_req_o),
    .ovf_err_o    (ovf_err_o),
    .unf_err_o    (unf_err_o)
  );
endmodule

// File: rtl/dfifo_checker.sv
module dfifo_checker #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_clr_i,
  input logic          dir_tx_i,
  input logic          dma_kick_i,
  input logic          card_out_valid_o,
  input logic          card_in_ready_o,
  input logic [LW-1:0] level_o,
  input logic          tx_ready_o,
  input logic          rx_ready_o,
  input logic          dma_req_o,
  input logic          ovf_err_o,
  input logic          unf_err_o
);
  assert_level_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));
  assert_clear_empties_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> (level_o == '0 && !ovf_err_o && !unf_err_o));
  assert_txrdy_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (dir_tx_i && !fifo_clr_i));
  assert_rxrdy_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> (!dir_tx_i && !fifo_clr_i));
  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_err_o && !fifo_clr_i) |=> ovf_err_o);
  assert_unf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_err_o && !fifo_clr_i) |=> unf_err_o);
  assert_full_refuse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == LW'(DEPTH)) |-> !card_in_ready_o);
  assert_out_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_out_valid_o |-> (dir_tx_i && level_o != '0));
  assert_dma_unarmed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fifo_clr_i) && !$past(dma_kick_i) && dir_tx_i) |-> !dma_req_o);
endmodule

bind dir_data_fifo dfifo_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .fifo_clr_i       (fifo_clr_i),
  .dir_tx_i         (dir_tx_i),
  .dma_kick_i       (dma_kick_i),
  .card_out_valid_o (card_out_valid_o),
  .card_in_ready_o  (card_in_ready_o),
  .level_o          (level_o),
  .tx_ready_o       (tx_ready_o),
  .rx_ready_o       (rx_ready_o),
  .dma_req_o        (dma_req_o),
  .ovf_err_o        (ovf_err_o),
  .unf_err_o        (unf_err_o)
);

// File: tb/tb_dir_data_fifo.sv
module tb_dir_data_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, dir_tx = 1'b0, thr = 1'b0, kick = 1'b0;
  logic [1:0]  aw = 2'd0;
  logic        wr = 1'b0, rd = 1'b0, drain = 1'b0, cin_v = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  cin_b = '0;
  logic [31:0] rdata;
  logic        cout_v, cin_rdy, tx_rdy, rx_rdy, dreq, ovf, unf;
  logic [7:0]  cout_b;
  logic [6:0]  level;

  int n_chk = 0, n_fail = 0;
  logic [7:0] q[$];

  always #2 clk = ~clk;

  dir_data_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_clr_i(clr), .dir_tx_i(dir_tx),
    .thresh_sel_i(thr), .acc_width_i(aw), .dma_kick_i(kick),
    .host_wr_i(wr), .host_wdata_i(wdata), .host_rd_i(rd), .host_rdata_o(rdata),
    .card_out_valid_o(cout_v), .card_out_byte_o(cout_b), .card_out_ready_i(drain),
    .card_in_valid_i(cin_v), .card_in_byte_i(cin_b), .card_in_ready_o(cin_rdy),
    .level_o(level), .tx_ready_o(tx_rdy), .rx_ready_o(rx_rdy), .dma_req_o(dreq),
    .ovf_err_o(ovf), .unf_err_o(unf)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  function automatic int thr_val();
    return thr ? 32 : 16;
  endfunction

  task automatic chk_level(input string req);
    chk(level == 7'(q.size()), req, level, q.size());
  endtask

  task automatic host_wr(input logic [1:0] w, input logic [31:0] d);
    int nb = nbytes(w);
    @(negedge clk);
    aw = w; wdata = d; wr = 1'b1;
    if (!clr && dir_tx && (64 - q.size()) >= nb)
      for (int k = 0; k < nb; k++) q.push_back(d[k*8 +: 8]);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] w, input string req);
    int nb = nbytes(w);
    logic [31:0] exp;
    @(negedge clk);
    aw = w; rd = 1'b1;
    #1;
    if (!clr && !dir_tx && q.size() >= nb) begin
      exp = '0;
      for (int k = 0; k < nb; k++) exp[k*8 +: 8] = q.pop_front();
      chk(rdata == exp, req, rdata, exp);
    end
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic card_push(input logic [7:0] b, input string req);
    bit acc;
    @(negedge clk);
    cin_v = 1'b1; cin_b = b;
    #1;
    acc = !clr && !dir_tx && q.size() < 64;
    chk(cin_rdy == acc, req, cin_rdy, acc);
    if (acc) q.push_back(b);
    @(negedge clk);
    cin_v = 1'b0;
  endtask

  task automatic drain_all();
    @(negedge clk);
    drain = 1'b1;
    repeat (70) @(negedge clk);
    drain = 1'b0;
  endtask

  // Monitor: transmit bytes leaving toward the card side, in order (R2)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (cout_v && drain) begin
        if (q.size() == 0) chk(1'b0, "R2 unexpected byte", cout_b, 0);
        else begin
          logic [7:0] e;
          e = q.pop_front();
          chk(cout_b == e, "R2/R6 card byte order", cout_b, e);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(level == 0 && !tx_rdy && !rx_rdy && !dreq && !ovf && !unf && !cout_v,
        "R1 reset state", {level, tx_rdy, rx_rdy, dreq, ovf, unf}, 0);

    // Transmit fill
    dir_tx = 1'b1; thr = 1'b0;
    @(negedge clk);
    chk(tx_rdy == 1'b1, "R4 tx_ready empty", tx_rdy, 1);
    chk(dreq == 1'b0, "R9 dma not armed", dreq, 0);
    for (int i = 0; i < 12; i++)
      host_wr(2'd2, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    chk_level("R6 width 4 level");
    chk(tx_rdy == 1'b1, "R3 thr16 free 16", tx_rdy, 1);
    thr = 1'b1; #1;
    chk(tx_rdy == 1'b0, "R3 thr32 free 16", tx_rdy, 0);
    thr = 1'b0;
    for (int i = 12; i < 16; i++)
      host_wr(2'd2, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    chk_level("R10 full level");
    chk(tx_rdy == 1'b0, "R4 tx_ready full", tx_rdy, 0);
    host_wr(2'd0, 32'hEE);
    chk(ovf == 1'b1, "R7 overflow flag", ovf, 1);
    chk_level("R7 overflow dropped");
    card_push(8'h5A, "R2 card in refused tx");
    chk_level("R2 card in no effect tx");

    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    chk(dreq == 1'b0, "R9 armed but full", dreq, 0);
    drain_all();
    chk_level("R2 drained");
    chk(dreq == 1'b1, "R9 armed and room", dreq, 1);
    chk(ovf == 1'b1, "R7 overflow sticky", ovf, 1);

    // Clear behaviour
    @(negedge clk); clr = 1'b1;
    host_wr(2'd2, 32'h11223344);
    #1;
    chk(level == 0 && !ovf && !dreq && !tx_rdy, "R1 held clear",
        {level, ovf, dreq, tx_rdy}, 0);
    @(negedge clk); clr = 1'b0;
    @(negedge clk);
    chk(dreq == 1'b0, "R9 arm cleared", dreq, 0);
    chk_level("R1 empty after release");

    // Width codes on transmit
    host_wr(2'd0, 32'hAABBCC11);
    host_wr(2'd1, 32'hAABB3322);
    host_wr(2'd3, 32'h77665544);
    chk_level("R6 widths 1+2+4");
    drain_all();

    // Receive mode
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; dir_tx = 1'b0;
    host_wr(2'd2, 32'hDEADBEEF);
    chk(level == 0 && !ovf, "R2 host write ignored rx", {level, ovf}, 0);
    for (int i = 0; i < 20; i++) card_push(8'(i*7+3), "R2 card in accept");
    chk_level("R10 rx level");
    chk(rx_rdy == 1'b1 && dreq == 1'b1, "R5/R9 rx thr16", {rx_rdy, dreq}, 2'b11);
    thr = 1'b1; #1;
    chk(rx_rdy == 1'b0 && dreq == 1'b0, "R3 rx thr32", {rx_rdy, dreq}, 0);
    chk(cout_v == 1'b0, "R2 no card out in rx", cout_v, 0);
    host_rd(2'd2, "R6 read width 4");
    host_rd(2'd1, "R6 read width 2");
    host_rd(2'd0, "R6 read width 1");
    host_rd(2'd2, "R6 read width 4b");
    host_rd(2'd2, "R6 read width 4c");
    host_rd(2'd3, "R6 read code 3");
    chk_level("R10 after reads");
    host_rd(2'd2, "R8 read short");
    chk(unf == 1'b1, "R8 underflow flag", unf, 1);
    chk_level("R8 underflow dropped");
    host_rd(2'd0, "R8 read last byte");
    chk(unf == 1'b1 && level == 0, "R8 sticky and empty", {unf, level}, 8'h80);

    for (int i = 0; i < 66; i++) card_push(8'(i ^ 8'h3C), "R10 fill to full");
    chk_level("R10 full rx");
    chk(rx_rdy == 1'b1, "R5 rx full thr32", rx_rdy, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule